// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of instruction bytes ahead of the execution side. A fetch controller reads 16-bit words from instruction memory on its own schedule. It writes the two bytes of each word into a six-entry circular byte store. The consumer removes one byte per cycle with a pop strobe. Fetching runs in parallel with consumption: whenever there is room for a whole word, the controller asks memory for the next one. It does not wait for the store to drain.

The physical fetch address comes from two values. One is a 16-bit segment value. The other is a 16-bit fetch pointer, and memory is always read at the even word that contains it. A redirect strobe (a taken jump) loads a new segment and pointer. In the same cycle it empties the store. If a memory response is still outstanding when the redirect arrives, that response is absorbed and thrown away when it returns. If the new pointer is odd, the low byte of the first word is skipped.

The fetch controller has four states:
- FS_IDLE: waiting for at least two free slots.
- FS_REQ: request raised and held until memory grants it.
- FS_WAIT: granted and waiting for the data.
- FS_DRAIN: a redirect arrived while a response was owed, so that response will be discarded.

Its transitions are:
- IDLE to REQ when there is room and no redirect.
- REQ to WAIT on a grant.
- REQ to DRAIN on a grant in the same cycle as a redirect.
- REQ stays in REQ, at the new address, on a redirect without a grant.
- WAIT to IDLE when the data arrives. The data is kept, unless a redirect comes in the same cycle.
- WAIT to DRAIN on a redirect before the data arrives.
- DRAIN to IDLE when the data arrives. The data is discarded.

Top module: `prefetch_bq`

## Requirements
- R1: The memory address equals (segment << 4) + (fetch pointer with bit 0 cleared), truncated to 20 bits. It is always even. The fetch pointer wraps from 0xFFFF to 0x0000.
- R2: The store never holds more than 6 bytes. A word request is raised only while at least 2 slots are free. When no bytes are popped after an even target, exactly 3 words are fetched (6 bytes). After an odd target, also exactly 3 words are fetched (5 bytes).
- R3: Bytes leave in ascending address order. Bits [7:0] of a memory word are the byte at the even address, and bits [15:8] are the byte at the next address.
- R4: A redirect empties the store. In the following cycle the valid output is low, and no byte fetched before the redirect is ever delivered.
- R5: After a redirect to an odd pointer, the first byte delivered is the byte at that odd address.
- R6: A memory response that is outstanding when a redirect occurs is not written into the store.
- R7: A pop while the valid output is low returns nothing and changes nothing. The later stream still starts at the correct byte.
- R8: When a redirect and a pop fall in the same cycle, the redirect wins. No byte of the new stream is consumed by that pop.
- R9: After reset the store is empty, no request is raised, and fetching starts at segment 0xFFFF, pointer 0x0000.
- R10: A raised request stays raised, with a stable address, until it is granted, unless a redirect arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Jump strobe: flush the store and restart fetching |
| redirect_cs | input | 16 | Segment value to load on a redirect |
| redirect_ip | input | 16 | Fetch pointer to load on a redirect |
| pop | input | 1 | Consumer takes the head byte this cycle |
| byte_out | output | 8 | Head byte of the store |
| byte_valid | output | 1 | The store holds at least one byte |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 20 | Even physical address of the requested word |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 16 | Read word, low byte at the even address |

## Verification
The bench builds the block with its default parameters: a depth of 6 bytes, 16-bit segment and pointer, a 20-bit address, and reset vector 0xFFFF:0x0000.

Even and odd targets reach both fill limits, 6 bytes and 5 bytes. Targets near 0xFFFF reach the 16-bit pointer wrap and the 20-bit address truncation.

A memory model with a programmable response latency and an alternating grant places redirects in every fetch state. This includes a redirect while a response is owed and a redirect while a request is still ungranted.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int BYTE_W = 8;
    localparam int BUS_W  = 16;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT,
        FS_DRAIN
    } fetch_state_e;

endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
    parameter int SEGW  = 16,
    parameter int IPW   = 16,
    parameter int PAW   = 20,
    parameter int SHIFT = 4
) (
    input  logic [SEGW-1:0] seg,
    input  logic [IPW-1:0]  ptr,
    output logic [PAW-1:0]  addr
);

    logic [PAW-1:0] seg_base;
    logic [PAW-1:0] word_off;

    // Segment scaled by 16, pointer rounded down to its word.
    assign seg_base = PAW'({seg, {SHIFT{1'b0}}});
    assign word_off = PAW'({ptr[IPW-1:1], 1'b0});
    assign addr     = seg_base + word_off;

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    wr_cnt,
    input  byte_t         wr_b0,
    input  byte_t         wr_b1,
    input  logic          pop_req,
    output byte_t         head,
    output logic          head_valid,
    output logic [CW-1:0] level,
    output logic [PW-1:0] rd_idx
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    function automatic logic [PW-1:0] step(input logic [PW-1:0] i);
        return (i == LAST) ? '0 : i + 1'b1;
    endfunction

    logic [PW-1:0] wr_idx;
    logic [PW-1:0] wr_idx_p1;
    logic          pop_ok;
    byte_t         slot [DEPTH];

    assign wr_idx_p1  = step(wr_idx);
    assign head_valid = (level != '0);
    assign pop_ok     = pop_req && head_valid && !flush;
    assign head       = slot[rd_idx];

    // Pointer and fill-level bookkeeping; flush overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
        end else begin
            unique case (wr_cnt)
                2'd1:    wr_idx <= wr_idx_p1;
                2'd2:    wr_idx <= step(wr_idx_p1);
                default: wr_idx <= wr_idx;
            endcase
            if (pop_ok) begin
                rd_idx <= step(rd_idx);
            end
            level <= CW'(level + CW'(wr_cnt) - CW'(pop_ok));
        end
    end

    // One write-enable decode per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_lo;
        logic hit_hi;
        assign hit_lo = !flush && (wr_cnt != 2'd0) && (wr_idx == PW'(g));
        assign hit_hi = !flush && (wr_cnt == 2'd2) && (wr_idx_p1 == PW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (hit_lo) begin
                slot[g] <= wr_b0;
            end else if (hit_hi) begin
                slot[g] <= wr_b1;
            end
        end
    end

endmodule

// File: rtl/pfq_fetch_fsm.sv
module pfq_fetch_fsm
    import pfq_pkg::*;
#(
    parameter int              DEPTH  = 6,
    parameter int              CW     = $clog2(DEPTH + 1),
    parameter int              SEGW   = 16,
    parameter int              IPW    = 16,
    parameter logic [SEGW-1:0] RST_CS = '1,
    parameter logic [IPW-1:0]  RST_IP = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [SEGW-1:0] tgt_cs,
    input  logic [IPW-1:0]  tgt_ip,
    input  logic [CW-1:0]   level,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    input  logic [BUS_W-1:0] mem_rdata,
    output logic            mem_req,
    output logic [SEGW-1:0] cur_cs,
    output logic [IPW-1:0]  cur_ptr,
    output logic [1:0]      wr_cnt,
    output byte_t           wr_b0,
    output byte_t           wr_b1
);

    localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);

    fetch_state_e state, state_nx;
    logic         skip_lo;
    logic         take_word;
    logic         has_room;

    assign has_room = (level <= ROOM_MAX);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: begin
                if (!redirect && has_room) begin
                    state_nx = FS_REQ;
                end
            end
            FS_REQ: begin
                if (mem_gnt) begin
                    state_nx = redirect ? FS_DRAIN : FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (mem_rvalid) begin
                    state_nx = FS_IDLE;
                end else if (redirect) begin
                    state_nx = FS_DRAIN;
                end
            end
            FS_DRAIN: begin
                if (mem_rvalid) begin
                    state_nx = FS_IDLE;
                end
            end
            default: state_nx = FS_IDLE;
        endcase
    end

    // Outputs: request strobe and byte write into the store.
    always_comb begin
        mem_req   = 1'b0;
        take_word = 1'b0;
        unique case (state)
            FS_REQ:  mem_req   = 1'b1;
            FS_WAIT: take_word = mem_rvalid && !redirect;
            default: ;
        endcase
        wr_cnt = take_word ? (skip_lo ? 2'd1 : 2'd2) : 2'd0;
        wr_b0  = skip_lo ? mem_rdata[2*BYTE_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
        wr_b1  = mem_rdata[2*BYTE_W-1:BYTE_W];
    end

    // Segment, pointer and odd-target skip flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cs  <= RST_CS;
            cur_ptr <= RST_IP;
            skip_lo <= RST_IP[0];
        end else if (redirect) begin
            cur_cs  <= tgt_cs;
            cur_ptr <= tgt_ip;
            skip_lo <= tgt_ip[0];
        end else if (take_word) begin
            cur_ptr <= {cur_ptr[IPW-1:1] + 1'b1, 1'b0};
            skip_lo <= 1'b0;
        end
    end

endmodule

// File: rtl/prefetch_bq.sv
module prefetch_bq
    import pfq_pkg::*;
#(
    parameter int              QDEPTH = 6,
    parameter int              SEGW   = 16,
    parameter int              IPW    = 16,
    parameter int              PAW    = 20,
    parameter logic [SEGW-1:0] RST_CS = '1,
    parameter logic [IPW-1:0]  RST_IP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect,
    input  logic [SEGW-1:0]  redirect_cs,
    input  logic [IPW-1:0]   redirect_ip,
    input  logic             pop,
    output logic [BYTE_W-1:0] byte_out,
    output logic             byte_valid,
    output logic             mem_req,
    output logic [PAW-1:0]   mem_addr,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  logic [BUS_W-1:0] mem_rdata
);

    localparam int CW = $clog2(QDEPTH + 1);
    localparam int PW = $clog2(QDEPTH);

    logic [CW-1:0]   q_level;
    logic [PW-1:0]   q_rd_idx;
    logic [SEGW-1:0] cur_cs;
    logic [IPW-1:0]  cur_ptr;
    logic [1:0]      wr_cnt;
    byte_t           wr_b0;
    byte_t           wr_b1;

    pfq_fetch_fsm #(
        .DEPTH (QDEPTH),
        .CW    (CW),
        .SEGW  (SEGW),
        .IPW   (IPW),
        .RST_CS(RST_CS),
        .RST_IP(RST_IP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .redirect  (redirect),
        .tgt_cs    (redirect_cs),
        .tgt_ip    (redirect_ip),
        .level     (q_level),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .cur_cs    (cur_cs),
        .cur_ptr   (cur_ptr),
        .wr_cnt    (wr_cnt),
        .wr_b0     (wr_b0),
        .wr_b1     (wr_b1)
    );

    pfq_addr_gen #(
        .SEGW (SEGW),
        .IPW  (IPW),
        .PAW  (PAW),
        .SHIFT(4)
    ) u_agen (
        .seg (cur_cs),
        .ptr (cur_ptr),
        .addr(mem_addr)
    );

    pfq_byte_ring #(
        .DEPTH(QDEPTH),
        .CW   (CW),
        .PW   (PW)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redirect),
        .wr_cnt    (wr_cnt),
        .wr_b0     (wr_b0),
        .wr_b1     (wr_b1),
        .pop_req   (pop),
        .head      (byte_out),
        .head_valid(byte_valid),
        .level     (q_level),
        .rd_idx    (q_rd_idx)
    );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int QDEPTH = 6,
    parameter int PAW    = 20,
    parameter int CW     = $clog2(QDEPTH + 1),
    parameter int PW     = $clog2(QDEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           redirect,
    input logic           pop,
    input logic           byte_valid,
    input logic           mem_req,
    input logic           mem_gnt,
    input logic [PAW-1:0] mem_addr,
    input logic [CW-1:0]  q_level,
    input logic [PW-1:0]  q_rd_idx
);

    assert_level_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= CW'(QDEPTH));

    assert_req_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (q_level <= CW'(QDEPTH - 2)));

    assert_addr_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !redirect) |=> (mem_req && $stable(mem_addr)));

    assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !byte_valid);

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !byte_valid && !redirect) |=> $stable(q_rd_idx));

endmodule

bind prefetch_bq pfq_checker #(
    .QDEPTH(QDEPTH),
    .PAW   (PAW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .redirect  (redirect),
    .pop       (pop),
    .byte_valid(byte_valid),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .q_level   (q_level),
    .q_rd_idx  (q_rd_idx)
);

// File: tb/prefetch_bq_test.sv
`timescale 1ns/1ps
module prefetch_bq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_cs = '0;
    logic [15:0] redirect_ip = '0;
    logic        pop = 1'b0;
    logic [7:0]  byte_out;
    logic        byte_valid;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    prefetch_bq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect   (redirect),
        .redirect_cs(redirect_cs),
        .redirect_ip(redirect_ip),
        .pop        (pop),
        .byte_out   (byte_out),
        .byte_valid (byte_valid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_tag = "R9";

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h3C;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] cs, input logic [15:0] ip);
        return 20'({cs, 4'h0}) + 20'(ip);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Memory model: one outstanding read, programmable latency.
    int          mem_lat = 0;
    bit          gnt_alt = 0;
    bit          pend = 0;
    int          pcnt = 0;
    logic [19:0] paddr = '0;
    int          grants = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (!rst_n) begin
            pend    <= 0;
            mem_gnt <= 1'b1;
        end else begin
            mem_gnt <= gnt_alt ? ~mem_gnt : 1'b1;
            if (pend) begin
                if (pcnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= {mbyte(paddr + 20'd1), mbyte(paddr)};
                    pend       <= 0;
                end else begin
                    pcnt <= pcnt - 1;
                end
            end
            if (mem_req && mem_gnt) begin
                pend   <= 1;
                paddr  <= mem_addr;
                pcnt   <= mem_lat;
                grants <= grants + 1;
            end
        end
    end

    // Scoreboard.
    logic [7:0]  q_exp[$];
    logic [15:0] exp_cs = 16'hFFFF;
    logic [15:0] exp_ip = 16'h0000;
    int          gbase = 0;

    always @(negedge clk) begin
        if (rst_n && pop && byte_valid && !redirect) begin
            if (q_exp.size() == 0) begin
                check(0, {cur_tag, " unexpected byte"}, byte_out, 0);
            end else begin
                logic [7:0] e;
                e = q_exp.pop_front();
                check(byte_out == e, {cur_tag, " R3 byte order"}, byte_out, e);
            end
        end
    end

    task automatic expect_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            q_exp.push_back(mbyte(phys(exp_cs, exp_ip)));
            exp_ip = exp_ip + 16'd1;
        end
    endtask

    task automatic consume(input int n, input int gap);
        int got = 0;
        while (got < n) begin
            pop = 1'b1;
            @(negedge clk);
            if (byte_valid) got++;
            @(posedge clk); #1;
            if (gap > 0) begin
                pop = 1'b0;
                repeat (gap) @(posedge clk);
                #1;
            end
        end
        pop = 1'b0;
        check(q_exp.size() == 0, {cur_tag, " R3 stream drained"}, q_exp.size(), 0);
    endtask

    task automatic take(input int n, input int gap);
        expect_bytes(n);
        consume(n, gap);
    endtask

    task automatic jump(input logic [15:0] cs, input logic [15:0] ip);
        redirect    = 1'b1;
        redirect_cs = cs;
        redirect_ip = ip;
        q_exp.delete();
        exp_cs = cs;
        exp_ip = ip;
        @(posedge clk); #1;
        redirect = 1'b0;
        gbase    = grants;
        @(negedge clk);
        check(!byte_valid, {cur_tag, " R4 empty after redirect"}, byte_valid, 0);
        @(posedge clk); #1;
    endtask

    task automatic first_addr(input logic [19:0] exp, input string tag);
        int guard = 0;
        @(negedge clk);
        while (!(mem_req && mem_gnt) && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check(mem_addr == exp, tag, mem_addr, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        // Reset state R9.
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check(!byte_valid, "R9 empty in reset", byte_valid, 0);
        check(!mem_req, "R9 no request in reset", mem_req, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!byte_valid, "R9 empty after reset", byte_valid, 0);
        check(!mem_req, "R9 idle after reset", mem_req, 0);
        @(posedge clk); #1;
        first_addr(20'hFFFF0, "R9 R1 reset vector address");
        cur_tag = "R9";
        take(8, 0);

        // R1 address and R2 fill limit, even target.
        cur_tag = "R2";
        jump(16'h1234, 16'h0100);
        first_addr(phys(16'h1234, 16'h0100), "R1 address formation");
        repeat (40) @(posedge clk);
        #1;
        @(negedge clk);
        check(!mem_req, "R2 request stops when full", mem_req, 0);
        check(byte_valid, "R2 bytes held", byte_valid, 1);
        check(grants - gbase == 3, "R2 words fetched even target", grants - gbase, 3);
        @(posedge clk); #1;
        take(10, 0);

        // R5 odd target, R2 fill limit with 5 bytes.
        cur_tag = "R5";
        jump(16'h0800, 16'h0041);
        repeat (40) @(posedge clk);
        #1;
        @(negedge clk);
        check(grants - gbase == 3, "R2 words fetched odd target", grants - gbase, 3);
        check(byte_out == mbyte(phys(16'h0800, 16'h0041)), "R5 first byte is target",
              byte_out, mbyte(phys(16'h0800, 16'h0041)));
        @(posedge clk); #1;
        take(9, 1);

        // R6 redirect while a response is owed.
        cur_tag = "R6";
        mem_lat = 6;
        jump(16'h4000, 16'h0010);
        take(3, 0);
        @(negedge clk);
        while (!(mem_req && mem_gnt)) @(negedge clk);
        @(posedge clk); #1;
        jump(16'h5A5A, 16'h2222);
        take(8, 0);

        // R7 pops on an empty store.
        cur_tag = "R7";
        jump(16'h0F0F, 16'h0303);
        pop = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!byte_valid, "R7 empty while popping", byte_valid, 0);
            @(posedge clk); #1;
        end
        pop = 1'b0;
        take(7, 0);

        // R8 redirect and pop in the same cycle.
        cur_tag = "R8";
        mem_lat = 0;
        jump(16'h3000, 16'h0000);
        repeat (30) @(posedge clk);
        #1;
        pop = 1'b1;
        jump(16'h3100, 16'h0007);
        pop = 1'b0;
        take(6, 0);

        // R10 alternating grant with latency; redirects land in REQ.
        cur_tag = "R10";
        gnt_alt = 1;
        mem_lat = 2;
        jump(16'h7000, 16'h0120);
        take(12, 1);
        jump(16'h7100, 16'h0001);
        take(10, 0);
        gnt_alt = 0;

        // R1 pointer wrap and 20-bit truncation.
        cur_tag = "R1";
        mem_lat = 0;
        jump(16'h2000, 16'hFFFD);
        take(8, 0);
        jump(16'hFFFF, 16'hFFF0);
        first_addr(20'h0FFE0, "R1 20-bit truncation");
        take(6, 0);

        repeat (5) @(posedge clk);
        report();
    end

endmodule